// File: doc/BRIEF.md
# Debug Halt Mode Controller

This block puts a processor core into a static debug halt and takes it out again. There are three ways in. A decoded test-port begin command stops the core at the next instruction boundary. The active-low run/stop pin, once it has been synchronised, stops the core as soon as it has drained. A debug exception event enters the halt at once, but only when the exception-halt enable bit is set. In every case the core is told to stall, and a ready output rises when the halt is complete. While the core is halted, a debugger uses test-port build commands to fill a two-lane injected micro-operation word half by half. It then sends an execute command, which issues both lanes together as a one-cycle strobe.

The way out depends on which source caused the halt. A halt entered by command or by exception ends on a test-port end command, or on the run/stop pin returning high after having been pulled low. A halt entered by the pin ends only when the pin is high again, and the end command has no effect on it. Interrupt and exception pulses that arrive while the core is stalled are collected. They are delivered in the first cycle after the stall drops.

Top module: `dbgHaltTop`

## Requirements
- R1: In reset, and on the first cycle after it, stallCore, haltReady and issueStrobe are 0, irqOut is 0 for a zero irqIn, and entrySrc is 0.
- R2: A cmdBegin pulse seen while running sets stallCore on the next edge, with entrySrc=1. haltReady rises only on the edge after instrBoundary is seen with the stall already in place.
- R3: A low level on runStopN is seen two edges later through a two-flop synchroniser. The next edge sets stallCore with entrySrc=2, and haltReady rises on the edge after coreDrained is seen.
- R4: When excEn=1, any of the five dbgEvents bits raises stallCore and haltReady together on the next edge, with entrySrc=3. The bits are breakpoint (0), single-step (1), task trap (2), general-detect access (3) and breakpoint instruction (4). When excEn=0 the events have no effect.
- R5: Requests that arrive in the same cycle are taken in the order pin (2), then command (1), then exception (3).
- R6: While stallCore is 1, any further entry request is ignored and entrySrc does not change.
- R7: A halt with entrySrc 1 or 3 ends on cmdEnd, or on a synchronised rising edge of runStopN.
- R8: A halt with entrySrc 2 ends only when the synchronised runStopN is high. cmdEnd has no effect on it.
- R9: On exit, stallCore and haltReady fall on the same edge and entrySrc returns to 0. Exit happens only from the ready state.
- R10: cmdBuild while haltReady=1 writes buildData into lane B when buildHi=1 and into lane A when buildHi=0. The last write to a lane wins. Builds made outside the ready state are ignored.
- R11: cmdExec while haltReady=1 gives a one-cycle issueStrobe on the next edge, with laneWordA and laneWordB holding the current lanes. A further execute is ignored until laneDone returns, and an execute made outside the ready state is ignored.
- R12: irqOut is 0 while stallCore=1. Pulses that arrive on irqIn during the stall are collected and appear on irqOut in the first cycle with stallCore=0. When the core is not stalled, irqIn passes straight through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| runStopN | input | 1 | Asynchronous active-low run/stop pin |
| cmdBegin | input | 1 | Test-port begin-halt command strobe |
| cmdEnd | input | 1 | Test-port end-halt command strobe |
| cmdBuild | input | 1 | Test-port build command strobe |
| cmdExec | input | 1 | Test-port execute command strobe |
| buildHi | input | 1 | Build target: 1 for lane B, 0 for lane A |
| buildData | input | LANE_W | Data for the build command |
| excEn | input | 1 | Exception-halt enable (control bit 0) |
| dbgEvents | input | EVT_N | Debug exception event pulses |
| instrBoundary | input | 1 | Core is at an instruction boundary |
| coreDrained | input | 1 | Core pipeline has drained |
| laneDone | input | 1 | Injected operation completed |
| irqIn | input | IRQ_N | Interrupt and exception pulses from the core |
| stallCore | output | 1 | Freeze fetch and decode |
| haltReady | output | 1 | Halt complete; ready for injected operations |
| entrySrc | output | 2 | Entry source: 0 none, 1 command, 2 pin, 3 exception |
| issueStrobe | output | 1 | One-cycle issue of the injected word |
| laneWordA | output | LANE_W | Injected micro-operation for lane A |
| laneWordB | output | LANE_W | Injected micro-operation for lane B |
| irqOut | output | IRQ_N | Interrupt pulses delivered to the core |

## Verification
Directed sequences run each entry source through each exit path. The begin command is held off for several cycles before instrBoundary arrives, and the pin entry is held off before coreDrained arrives, so that the time the stall rises can be told apart from the time ready rises. Entry requests are also raised together and while already halted, which separates the priority rule from the rule that second requests are ignored. cmdEnd is sent into a pin-entered halt to show that the exit rule depends on the source. A long stretch of random commands, events and pin toggles follows, compared every cycle against the reference model, to catch lost interrupts, repeated issue while busy, and builds accepted in the wrong state.

// File: rtl/dbgHaltPkg.sv
package dbgHaltPkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_CMD  = 2'd1,
    SRC_PIN  = 2'd2,
    SRC_EXC  = 2'd3
  } entrySrcT;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_HALT  = 2'd2
  } haltStT;

  // strobes from control to datapath
  typedef struct packed {
    logic buildWr;
    logic buildHi;
    logic execGo;
    logic coreHeld;
  } dpCtlT;
endpackage

// File: rtl/dbgPinSync.sv
module dbgPinSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinN,
  output logic pinLevel,
  output logic pinRise
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;
  logic          prevLevel;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : gStage
      if (i == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (!rstN) chain[0] <= 1'b1;
          else       chain[0] <= pinN;
        end
      end else begin : gNext
        always_ff @(posedge clk) begin
          if (!rstN) chain[i] <= 1'b1;
          else       chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) prevLevel <= 1'b1;
    else       prevLevel <= chain[LAST];
  end

  assign pinLevel = chain[LAST];
  assign pinRise  = chain[LAST] & ~prevLevel;
endmodule

// File: rtl/dbgHaltFsm.sv
module dbgHaltFsm
  import dbgHaltPkg::*;
#(
  parameter int EVT_N = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdBegin,
  input  logic             cmdEnd,
  input  logic             cmdBuild,
  input  logic             buildHi,
  input  logic             cmdExec,
  input  logic             pinLevel,
  input  logic             pinRise,
  input  logic             excEn,
  input  logic [EVT_N-1:0] dbgEvents,
  input  logic             instrBoundary,
  input  logic             coreDrained,
  output dpCtlT            ctl,
  output logic             haltReady,
  output logic [1:0]       entrySrc
);
  haltStT   state, stateNext;
  entrySrcT src, srcNext;
  logic     excReq, exitReq, drainDone;

  assign excReq = excEn & (|dbgEvents);

  // the exit conditions depend on the recorded entry source
  always_comb begin
    unique case (src)
      SRC_PIN: exitReq = pinLevel;
      SRC_CMD,
      SRC_EXC: exitReq = cmdEnd | pinRise;
      default: exitReq = 1'b0;
    endcase
  end

  assign drainDone = (src == SRC_CMD) ? instrBoundary :
                     (src == SRC_PIN) ? coreDrained : 1'b0;

  always_comb begin
    stateNext = state;
    srcNext   = src;
    unique case (state)
      ST_RUN: begin
        if (!pinLevel) begin
          stateNext = ST_DRAIN;
          srcNext   = SRC_PIN;
        end else if (cmdBegin) begin
          stateNext = ST_DRAIN;
          srcNext   = SRC_CMD;
        end else if (excReq) begin
          stateNext = ST_HALT;
          srcNext   = SRC_EXC;
        end
      end
      ST_DRAIN: begin
        if (drainDone) stateNext = ST_HALT;
      end
      ST_HALT: begin
        if (exitReq) begin
          stateNext = ST_RUN;
          srcNext   = SRC_NONE;
        end
      end
      default: begin
        stateNext = ST_RUN;
        srcNext   = SRC_NONE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_RUN;
      src   <= SRC_NONE;
    end else begin
      state <= stateNext;
      src   <= srcNext;
    end
  end

  assign haltReady    = (state == ST_HALT);
  assign entrySrc     = src;
  assign ctl.coreHeld = (state != ST_RUN);
  assign ctl.buildWr  = cmdBuild & haltReady;
  assign ctl.buildHi  = buildHi;
  assign ctl.execGo   = cmdExec & haltReady;
endmodule

// File: rtl/dbgHaltDp.sv
module dbgHaltDp
  import dbgHaltPkg::*;
#(
  parameter int LANE_W = 32,
  parameter int IRQ_N  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtlT             ctl,
  input  logic [LANE_W-1:0] buildData,
  input  logic              laneDone,
  input  logic [IRQ_N-1:0]  irqIn,
  output logic              issueStrobe,
  output logic [LANE_W-1:0] laneWordA,
  output logic [LANE_W-1:0] laneWordB,
  output logic [IRQ_N-1:0]  irqOut
);
  localparam int LANES = 2;

  logic [LANE_W-1:0] laneReg [LANES];
  logic              busy, goNow;
  logic [IRQ_N-1:0]  heldIrq;

  generate
    for (genvar l = 0; l < LANES; l++) begin : gLane
      logic laneSel;
      assign laneSel = (l == 1) ? ctl.buildHi : ~ctl.buildHi;
      always_ff @(posedge clk) begin
        if (!rstN)                      laneReg[l] <= '0;
        else if (ctl.buildWr && laneSel) laneReg[l] <= buildData;
      end
    end
  endgenerate

  assign goNow = ctl.execGo & ~busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy        <= 1'b0;
      issueStrobe <= 1'b0;
    end else begin
      issueStrobe <= goNow;
      if (goNow)         busy <= 1'b1;
      else if (laneDone) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             heldIrq <= '0;
    else if (ctl.coreHeld) heldIrq <= heldIrq | irqIn;
    else                   heldIrq <= '0;
  end

  assign irqOut    = ctl.coreHeld ? '0 : (irqIn | heldIrq);
  assign laneWordA = laneReg[0];
  assign laneWordB = laneReg[1];
endmodule

// File: rtl/dbgHaltTop.sv
module dbgHaltTop
  import dbgHaltPkg::*;
#(
  parameter int LANE_W      = 32,
  parameter int EVT_N       = 5,
  parameter int IRQ_N       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runStopN,
  input  logic              cmdBegin,
  input  logic              cmdEnd,
  input  logic              cmdBuild,
  input  logic              cmdExec,
  input  logic              buildHi,
  input  logic [LANE_W-1:0] buildData,
  input  logic              excEn,
  input  logic [EVT_N-1:0]  dbgEvents,
  input  logic              instrBoundary,
  input  logic              coreDrained,
  input  logic              laneDone,
  input  logic [IRQ_N-1:0]  irqIn,
  output logic              stallCore,
  output logic              haltReady,
  output logic [1:0]        entrySrc,
  output logic              issueStrobe,
  output logic [LANE_W-1:0] laneWordA,
  output logic [LANE_W-1:0] laneWordB,
  output logic [IRQ_N-1:0]  irqOut
);
  logic  pinLevel, pinRise;
  dpCtlT ctl;

  dbgPinSync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .pinN(runStopN),
    .pinLevel(pinLevel), .pinRise(pinRise)
  );

  dbgHaltFsm #(.EVT_N(EVT_N)) uFsm (
    .clk(clk), .rstN(rstN), .cmdBegin(cmdBegin), .cmdEnd(cmdEnd),
    .cmdBuild(cmdBuild), .buildHi(buildHi), .cmdExec(cmdExec),
    .pinLevel(pinLevel), .pinRise(pinRise), .excEn(excEn),
    .dbgEvents(dbgEvents), .instrBoundary(instrBoundary),
    .coreDrained(coreDrained), .ctl(ctl), .haltReady(haltReady),
    .entrySrc(entrySrc)
  );

  dbgHaltDp #(.LANE_W(LANE_W), .IRQ_N(IRQ_N)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .buildData(buildData),
    .laneDone(laneDone), .irqIn(irqIn), .issueStrobe(issueStrobe),
    .laneWordA(laneWordA), .laneWordB(laneWordB), .irqOut(irqOut)
  );

  assign stallCore = ctl.coreHeld;
endmodule

// File: rtl/dbgHaltChk.sv
module dbgHaltChk #(
  parameter int IRQ_N = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             stallCore,
  input logic             haltReady,
  input logic [1:0]       entrySrc,
  input logic             issueStrobe,
  input logic             cmdEnd,
  input logic             pinLevel,
  input logic [IRQ_N-1:0] irqOut
);
  assert_ready_needs_stall_R2: assert property (@(posedge clk) disable iff (!rstN)
    haltReady |-> stallCore);

  assert_src_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stallCore && $past(stallCore)) |-> $stable(entrySrc));

  assert_pin_halt_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (haltReady && entrySrc == 2'd2 && !pinLevel && cmdEnd) |=> haltReady);

  assert_exit_from_ready_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stallCore) |-> ($past(haltReady) && !haltReady && entrySrc == 2'd0));

  assert_src_tracks_stall_R9: assert property (@(posedge clk) disable iff (!rstN)
    stallCore == (entrySrc != 2'd0));

  assert_issue_in_halt_R11: assert property (@(posedge clk) disable iff (!rstN)
    issueStrobe |-> $past(haltReady));

  assert_issue_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    issueStrobe |=> !issueStrobe);

  assert_irq_blocked_R12: assert property (@(posedge clk) disable iff (!rstN)
    stallCore |-> (irqOut == '0));
endmodule

bind dbgHaltTop dbgHaltChk #(.IRQ_N(IRQ_N)) uChk (
  .clk(clk), .rstN(rstN), .stallCore(stallCore), .haltReady(haltReady),
  .entrySrc(entrySrc), .issueStrobe(issueStrobe), .cmdEnd(cmdEnd),
  .pinLevel(pinLevel), .irqOut(irqOut)
);

// File: tb/tb_dbgHaltTop.sv
module tb_dbgHaltTop;
  localparam int LW = 32;
  localparam int EN = 5;
  localparam int IN = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runStopN = 1'b1, cmdBegin = 0, cmdEnd = 0, cmdBuild = 0, cmdExec = 0, buildHi = 0;
  logic [LW-1:0] buildData = '0;
  logic excEn = 0;
  logic [EN-1:0] dbgEvents = '0;
  logic instrBoundary = 0, coreDrained = 0, laneDone = 0;
  logic [IN-1:0] irqIn = '0;
  logic stallCore, haltReady, issueStrobe;
  logic [1:0] entrySrc;
  logic [LW-1:0] laneWordA, laneWordB;
  logic [IN-1:0] irqOut;

  always #10 clk = ~clk;

  dbgHaltTop dut (.*);

  int vectors = 0;
  int fails = 0;
  string curReq = "R1";
  bit done = 0;

  // reference model state
  int mState = 0;  // 0 run, 1 drain, 2 halt
  int mSrc = 0;    // 0 none, 1 cmd, 2 pin, 3 exc
  bit s1 = 1, s2 = 1, sPrev = 1;
  bit mBusy = 0, mIssue = 0;
  logic [LW-1:0] mA = '0, mB = '0;
  logic [IN-1:0] mHeld = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mSrc = 0; s1 = 1; s2 = 1; sPrev = 1;
      mBusy = 0; mIssue = 0; mA = '0; mB = '0; mHeld = '0;
    end else begin
      bit halted, go, rise;
      halted = (mState == 2);
      rise = s2 && !sPrev;
      go = halted && cmdExec && !mBusy;
      if (halted && cmdBuild) begin
        if (buildHi) mB = buildData; else mA = buildData;
      end
      if (mState != 0) mHeld = mHeld | irqIn; else mHeld = '0;
      mIssue = go;
      if (go) mBusy = 1; else if (laneDone) mBusy = 0;
      case (mState)
        0: if (!s2) begin mState = 1; mSrc = 2; end
           else if (cmdBegin) begin mState = 1; mSrc = 1; end
           else if (excEn && |dbgEvents) begin mState = 2; mSrc = 3; end
        1: if ((mSrc == 1 && instrBoundary) || (mSrc == 2 && coreDrained)) mState = 2;
        default: begin
          if ((mSrc == 2 && s2) || (mSrc != 2 && (cmdEnd || rise))) begin
            mState = 0; mSrc = 0;
          end
        end
      endcase
      sPrev = s2; s2 = s1; s1 = runStopN;
    end
  end

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", curReq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    logic [IN-1:0] eIrq;
    eIrq = (mState != 0) ? '0 : (irqIn | mHeld);
    chk("stallCore", 64'(stallCore), 64'(mState != 0));
    chk("haltReady", 64'(haltReady), 64'(mState == 2));
    chk("entrySrc", 64'(entrySrc), 64'(mSrc));
    chk("issueStrobe", 64'(issueStrobe), 64'(mIssue));
    chk("irqOut", 64'(irqOut), 64'(eIrq));
    if (mIssue) begin
      chk("laneWordA", 64'(laneWordA), 64'(mA));
      chk("laneWordB", 64'(laneWordB), 64'(mB));
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic pulse(ref logic sig);
    sig = 1; step(); sig = 0;
  endtask

  task automatic build(bit hi, logic [LW-1:0] d);
    buildHi = hi; buildData = d; cmdBuild = 1; step(); cmdBuild = 0;
  endtask

  initial begin
    // R1: reset state
    curReq = "R1";
    step(3);
    rstN = 1;
    step(2);

    // R2: command entry waits for an instruction boundary
    curReq = "R2";
    pulse(cmdBegin);
    step(4);
    pulse(instrBoundary);
    step(2);
    // R10: repeated builds, last wins
    curReq = "R10";
    build(0, 32'h1111_0000);
    build(0, 32'hA5A5_0001);
    build(1, 32'h5A5A_0002);
    // R11: execute issues both lanes; second execute ignored while busy
    curReq = "R11";
    pulse(cmdExec);
    pulse(cmdExec);
    step(2);
    pulse(laneDone);
    pulse(cmdExec);
    pulse(laneDone);
    // R12: interrupts held during halt
    curReq = "R12";
    irqIn = 3'b101; step(); irqIn = 3'b000; step();
    // R7 / R9: end command exits a command halt
    curReq = "R7";
    pulse(cmdEnd);
    step(3);

    // R4: events ignored while disabled
    curReq = "R4";
    for (int b = 0; b < EN; b++) begin
      dbgEvents = EN'(1) << b; step(); dbgEvents = '0; step();
    end
    excEn = 1;
    for (int b = 0; b < EN; b++) begin
      curReq = "R4";
      dbgEvents = EN'(1) << b; step(); dbgEvents = '0; step(2);
      // R7: exit by pin low then high
      curReq = "R7";
      runStopN = 0; step(3); runStopN = 1; step(5);
    end
    excEn = 0;

    // R3: pin entry, ready only after drain
    curReq = "R3";
    runStopN = 0; step(6);
    pulse(coreDrained);
    step(2);
    // R8: end command ignored in a pin halt
    curReq = "R8";
    pulse(cmdEnd);
    step(3);
    // R6: further requests ignored while halted
    curReq = "R6";
    excEn = 1; cmdBegin = 1; dbgEvents = 5'b00001; step();
    cmdBegin = 0; dbgEvents = '0; excEn = 0; step();
    curReq = "R9";
    runStopN = 1; step(5);

    // R10 / R11: build and execute outside halt ignored
    curReq = "R10";
    build(1, 32'hDEAD_BEEF);
    curReq = "R11";
    pulse(cmdExec);
    step(2);

    // R5: simultaneous requests, pin wins
    curReq = "R5";
    runStopN = 0; step(2);
    cmdBegin = 1; excEn = 1; dbgEvents = 5'b10000; step();
    cmdBegin = 0; dbgEvents = '0; step(2);
    pulse(coreDrained);
    runStopN = 1; step(5);
    // command beats exception
    cmdBegin = 1; dbgEvents = 5'b00100; step();
    cmdBegin = 0; dbgEvents = '0; excEn = 0;
    pulse(instrBoundary);
    pulse(cmdEnd);
    step(3);

    // R12: pass-through while running
    curReq = "R12";
    irqIn = 3'b011; step(); irqIn = '0; step();

    // mixed random traffic
    curReq = "R7";
    for (int i = 0; i < 4000; i++) begin
      cmdBegin      = ($urandom_range(99) < 4);
      cmdEnd        = ($urandom_range(99) < 4);
      cmdBuild      = ($urandom_range(99) < 10);
      cmdExec       = ($urandom_range(99) < 10);
      buildHi       = 1'($urandom);
      buildData     = $urandom;
      laneDone      = ($urandom_range(99) < 20);
      instrBoundary = ($urandom_range(99) < 20);
      coreDrained   = ($urandom_range(99) < 20);
      dbgEvents     = ($urandom_range(99) < 4) ? EN'($urandom) : '0;
      irqIn         = ($urandom_range(99) < 10) ? IN'($urandom) : '0;
      if (i % 500 == 0) excEn = 1'($urandom);
      if ($urandom_range(99) < 2) runStopN = ~runStopN;
      step();
    end
    runStopN = 1; cmdBegin = 0; cmdEnd = 0; cmdBuild = 0; cmdExec = 0;
    dbgEvents = '0; irqIn = '0;
    step(5);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule